// File: doc/BRIEF.md
# Shared-Exponent Table for Convergent Block Scaling

This block keeps the per-block scaling state of an in-place, memory-based radix-2 FFT whose data is split into blocks that converge as the transform goes on. Each table entry pairs a shared exponent with a one-bit scale flag. The first stage has a single block. The block count then doubles every stage, so both inputs of any butterfly always come from the same block and share one exponent. Doubling stops once the count reaches a cap of `2**BMAX_LOG2`. From then on, each block keeps its own entry.

When the controller finishes a block, it issues one write. The write carries the stage number, the parent entry index and the two predicted flags for the children. In a splitting stage the table writes two children. One goes to the parent's slot and the other goes `2**BMAX_LOG2 >> (stage+1)` slots higher. Each child exponent is the parent exponent plus one when its flag is set, and it saturates at the top code. In a capped stage only the parent slot is rewritten. A registered read port gives the butterfly datapath the flag and exponent of the block it is working on. A start pulse clears the table for a new transform.

Top module: `blkexp_table`

## Requirements
- R1: After `rst` or a `start_i` pulse, every entry reads back exponent 0 and flag 0.
- R2: A read issued with `rd_en_i` returns data one cycle later with `rd_valid_o` high. `rd_valid_o` is low in every cycle that follows a cycle without `rd_en_i`. A read issued in the same cycle as a write to the same entry returns the value from before the write.
- R3: In a write whose stage value `s` is below `BMAX_LOG2` (a splitting stage), child A goes to entry `x = wr_idx_i`. Child B goes to entry `x + (2**BMAX_LOG2 >> (s+1))`, with the index taken modulo `2**BMAX_LOG2`. Stages are counted from 0.
- R4: Each child's exponent equals the parent's exponent from before the write when that child's flag is 0. It equals the parent's exponent plus one when the flag is 1.
- R5: In a write whose stage value is `BMAX_LOG2` or more (a capped stage), only entry `x` is rewritten, using `wr_flag_a_i`. `wr_flag_b_i` has no effect and all other entries are unchanged.
- R6: An exponent at its maximum code `2**EXP_W-1` stays at that code when incremented. It does not wrap.
- R7: When `start_i` and `wr_en_i` are high in the same cycle, the clear wins and the write is discarded.
- R8: The flag stored with each child is the flag given for that child in the write, and it is returned unchanged on `rd_flag_o`.
- R9: An entry that is neither written nor cleared keeps its exponent and flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Clears the table for a new transform |
| wr_en_i | input | 1 | Block finished: write its children |
| wr_stage_i | input | STG_W | Stage of the finished block, counted from 0 |
| wr_idx_i | input | IDX_W | Entry index of the finished (parent) block |
| wr_flag_a_i | input | 1 | Predicted scale flag of child A (slot x) |
| wr_flag_b_i | input | 1 | Predicted scale flag of child B (upper slot) |
| rd_en_i | input | 1 | Read request |
| rd_idx_i | input | IDX_W | Entry to read |
| rd_valid_o | output | 1 | Read data valid, one cycle after the request |
| rd_flag_o | output | 1 | Scale flag of the entry read |
| rd_exp_o | output | EXP_W | Shared exponent of the entry read |

## Verification
The bench targets the placement of the upper child in each splitting stage. A wrong offset shows up as a value landing in a sibling's slot, and a wrong stop point for doubling shows up as a capped write that overwrites a neighbour. It drives an exponent up to its top code and keeps incrementing it, which catches any design that wraps back to zero. It also checks that the increment uses the parent's value from before the write. A design that reads the parent after writing child A would give child B a double increment. Finally, it covers a read and a write to the same entry in the same cycle, and a start pulse that coincides with a write. A wrong priority in either case leaves stale or fresh data where the other was expected.

// File: rtl/blkexp_pkg.sv
package blkexp_pkg;
  // How a finished block maps onto the next stage's entries.
  typedef enum logic {
    WR_SPLIT = 1'b0,  // block divides into two children
    WR_HOLD  = 1'b1   // block count capped: block keeps its slot
  } wr_mode_e;
endpackage

// File: rtl/blkexp_child.sv
module blkexp_child #(
  parameter int EXP_W = 4
) (
  input  logic [EXP_W-1:0] par_exp_i,
  input  logic             flag_i,
  output logic [EXP_W-1:0] exp_o
);
  localparam logic [EXP_W-1:0] EXP_MAX = {EXP_W{1'b1}};

  // Exponent grows by one per scaled stage, clamped at the top code.
  always_comb begin
    if (!flag_i)                exp_o = par_exp_i;
    else if (par_exp_i == EXP_MAX) exp_o = EXP_MAX;
    else                        exp_o = par_exp_i + 1'b1;
  end
endmodule

// File: rtl/blkexp_store.sv
module blkexp_store #(
  parameter int EXP_W = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             we_a_i,
  input  logic [IDX_W-1:0] idx_a_i,
  input  logic [EXP_W-1:0] exp_a_i,
  input  logic             flag_a_i,
  input  logic             we_b_i,
  input  logic [IDX_W-1:0] idx_b_i,
  input  logic [EXP_W-1:0] exp_b_i,
  input  logic             flag_b_i,
  input  logic [IDX_W-1:0] par_idx_i,
  output logic [EXP_W-1:0] par_exp_o,
  input  logic             rd_en_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_valid_o,
  output logic [EXP_W-1:0] rd_exp_o,
  output logic             rd_flag_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic [EXP_W-1:0] exp_q  [DEPTH];
  logic             flag_q [DEPTH];

  // Parent exponent for the child calculators (pre-write value).
  assign par_exp_o = exp_q[par_idx_i];

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      for (int i = 0; i < DEPTH; i++) begin
        exp_q[i]  <= '0;
        flag_q[i] <= 1'b0;
      end
    end else begin
      if (we_a_i) begin
        exp_q[idx_a_i]  <= exp_a_i;
        flag_q[idx_a_i] <= flag_a_i;
      end
      if (we_b_i) begin
        exp_q[idx_b_i]  <= exp_b_i;
        flag_q[idx_b_i] <= flag_b_i;
      end
    end
  end

  // Registered read port, read-before-write.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_o <= 1'b0;
      rd_exp_o   <= '0;
      rd_flag_o  <= 1'b0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) begin
        rd_exp_o  <= exp_q[rd_idx_i];
        rd_flag_o <= flag_q[rd_idx_i];
      end
    end
  end
endmodule

// File: rtl/blkexp_table.sv
module blkexp_table
  import blkexp_pkg::*;
#(
  parameter int N_LOG2    = 10,
  parameter int BMAX_LOG2 = 2,
  localparam int EXP_W = $clog2(N_LOG2),
  localparam int STG_W = $clog2(N_LOG2),
  localparam int IDX_W = BMAX_LOG2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             wr_en_i,
  input  logic [STG_W-1:0] wr_stage_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_flag_a_i,
  input  logic             wr_flag_b_i,
  input  logic             rd_en_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_valid_o,
  output logic             rd_flag_o,
  output logic [EXP_W-1:0] rd_exp_o
);
  localparam int BMAX = 1 << BMAX_LOG2;

  wr_mode_e         mode;
  logic [IDX_W-1:0] span;
  logic [IDX_W-1:0] idx_b;
  logic [EXP_W-1:0] parent_exp;
  logic [1:0]       child_flag;
  logic [EXP_W-1:0] child_exp [2];

  // Splitting continues until the stage reaches the cap.
  assign mode  = (int'(wr_stage_i) < BMAX_LOG2) ? WR_SPLIT : WR_HOLD;
  // Distance to the upper child halves every stage.
  assign span  = IDX_W'((BMAX >> 1) >> wr_stage_i);
  assign idx_b = wr_idx_i + span;
  assign child_flag = {wr_flag_b_i, wr_flag_a_i};

  for (genvar c = 0; c < 2; c++) begin : g_child
    blkexp_child #(.EXP_W(EXP_W)) u_child (
      .par_exp_i (parent_exp),
      .flag_i    (child_flag[c]),
      .exp_o     (child_exp[c])
    );
  end

  blkexp_store #(.EXP_W(EXP_W), .IDX_W(IDX_W)) u_store (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (start_i),
    .we_a_i     (wr_en_i),
    .idx_a_i    (wr_idx_i),
    .exp_a_i    (child_exp[0]),
    .flag_a_i   (wr_flag_a_i),
    .we_b_i     (wr_en_i && (mode == WR_SPLIT)),
    .idx_b_i    (idx_b),
    .exp_b_i    (child_exp[1]),
    .flag_b_i   (wr_flag_b_i),
    .par_idx_i  (wr_idx_i),
    .par_exp_o  (parent_exp),
    .rd_en_i    (rd_en_i),
    .rd_idx_i   (rd_idx_i),
    .rd_valid_o (rd_valid_o),
    .rd_exp_o   (rd_exp_o),
    .rd_flag_o  (rd_flag_o)
  );
endmodule

// File: rtl/blkexp_table_chk.sv
module blkexp_table_chk #(
  parameter int EXP_W = 4,
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             wr_en_i,
  input logic             rd_en_i,
  input logic [IDX_W-1:0] rd_idx_i,
  input logic             rd_valid_o,
  input logic             rd_flag_o,
  input logic [EXP_W-1:0] rd_exp_o,
  input logic [EXP_W-1:0] parent_exp,
  input logic [EXP_W-1:0] child_exp_a,
  input logic             flag_a
);
  localparam logic [EXP_W-1:0] EXP_MAX = {EXP_W{1'b1}};

  AST_RD_VALID_HI: assert property (@(posedge clk) disable iff (rst)
    rd_en_i |=> rd_valid_o);  // R2
  AST_RD_VALID_LO: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> !rd_valid_o);  // R2
  AST_START_CLEAR: assert property (@(posedge clk) disable iff (rst)
    start_i ##1 (rd_en_i && !start_i) |=> (rd_exp_o == '0) && !rd_flag_o);  // R1
  AST_EXP_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && parent_exp == EXP_MAX) |-> child_exp_a == EXP_MAX);  // R6
  AST_CHILD_STEP: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && !flag_a) |-> child_exp_a == parent_exp);  // R4
  AST_ENTRY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && !wr_en_i && !start_i) ##1
    (rd_en_i && !wr_en_i && !start_i && $stable(rd_idx_i))
    |=> $stable(rd_exp_o) && $stable(rd_flag_o));  // R9
endmodule

bind blkexp_table blkexp_table_chk #(.EXP_W(EXP_W), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .wr_en_i     (wr_en_i),
  .rd_en_i     (rd_en_i),
  .rd_idx_i    (rd_idx_i),
  .rd_valid_o  (rd_valid_o),
  .rd_flag_o   (rd_flag_o),
  .rd_exp_o    (rd_exp_o),
  .parent_exp  (parent_exp),
  .child_exp_a (child_exp[0]),
  .flag_a      (wr_flag_a_i)
);

// File: tb/blkexp_table_tb_top.sv
module blkexp_table_tb_top;
  localparam int N_LOG2    = 10;
  localparam int BMAX_LOG2 = 2;
  localparam int EXP_W = $clog2(N_LOG2);
  localparam int STG_W = $clog2(N_LOG2);
  localparam int IDX_W = BMAX_LOG2;
  localparam int BMAX  = 1 << BMAX_LOG2;
  localparam logic [EXP_W-1:0] EXP_MAX = {EXP_W{1'b1}};

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic             rst, start_i, wr_en_i, wr_flag_a_i, wr_flag_b_i, rd_en_i;
  logic [STG_W-1:0] wr_stage_i;
  logic [IDX_W-1:0] wr_idx_i, rd_idx_i;
  logic             rd_valid_o, rd_flag_o;
  logic [EXP_W-1:0] rd_exp_o;

  blkexp_table #(.N_LOG2(N_LOG2), .BMAX_LOG2(BMAX_LOG2)) dut_i (.*);

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference table built from the requirements.
  logic [EXP_W-1:0] m_exp  [BMAX];
  logic             m_flag [BMAX];

  // Scoreboard: expected {flag, exp} with the requirement tag.
  logic [EXP_W:0] exp_q [$];
  string          tag_q [$];

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic logic [EXP_W-1:0] bump(input logic [EXP_W-1:0] e, input logic f);
    if (f && e != EXP_MAX) return e + 1'b1;
    return e;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < BMAX; i++) begin
      m_exp[i] = '0;
      m_flag[i] = 1'b0;
    end
  endtask

  task automatic model_write(input int s, input logic [IDX_W-1:0] x, input logic fa, input logic fb);
    logic [EXP_W-1:0] pe;
    logic [IDX_W-1:0] y;
    pe = m_exp[x];
    if (s < BMAX_LOG2) begin
      y = x + IDX_W'(BMAX >> (s + 1));
      m_exp[y] = bump(pe, fb);
      m_flag[y] = fb;
    end
    m_exp[x] = bump(pe, fa);
    m_flag[x] = fa;
  endtask

  task automatic idle();
    start_i = 0; wr_en_i = 0; rd_en_i = 0;
    wr_flag_a_i = 0; wr_flag_b_i = 0;
    @(negedge clk);
  endtask

  // Driver: one write per cycle.
  task automatic do_write(input int s, input logic [IDX_W-1:0] x, input logic fa, input logic fb);
    wr_en_i = 1; wr_stage_i = STG_W'(s); wr_idx_i = x;
    wr_flag_a_i = fa; wr_flag_b_i = fb;
    model_write(s, x, fa, fb);
    @(negedge clk);
    wr_en_i = 0;
  endtask

  // Driver: one read per cycle, expected value pushed to the scoreboard.
  task automatic do_read(input logic [IDX_W-1:0] x, input string tag);
    rd_en_i = 1; rd_idx_i = x;
    exp_q.push_back({m_flag[x], m_exp[x]});
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en_i = 0;
  endtask

  task automatic read_all(input string tag);
    for (int i = 0; i < BMAX; i++) do_read(IDX_W'(i), tag);
    idle();
  endtask

  // Monitor.
  always @(negedge clk) begin
    if (!rst && rd_valid_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected valid", 1, 0);
      end else begin
        logic [EXP_W:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({rd_flag_o, rd_exp_o} == e, t, int'({rd_flag_o, rd_exp_o}), int'(e));
      end
    end
  end

  initial begin
    rst = 1; start_i = 0; wr_en_i = 0; rd_en_i = 0;
    wr_stage_i = '0; wr_idx_i = '0; rd_idx_i = '0;
    wr_flag_a_i = 0; wr_flag_b_i = 0;
    model_clear();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(rd_valid_o == 1'b0, "R2 idle valid low after reset", int'(rd_valid_o), 0);
    read_all("R1 reset state");

    // Splitting stages 0 and 1, then capped stage 2.
    do_write(0, 2'd0, 1'b1, 1'b0);
    read_all("R3 stage0 split R8");
    do_write(1, 2'd0, 1'b0, 1'b1);
    do_write(1, 2'd2, 1'b1, 1'b1);
    read_all("R4 stage1 split R3");
    do_write(2, 2'd1, 1'b1, 1'b1);
    read_all("R5 capped stage flag_b ignored");
    chk(rd_valid_o == 1'b0, "R2 valid low when idle", int'(rd_valid_o), 0);

    // Saturation on entry 3.
    for (int i = 0; i < 18; i++) do_write(3, 2'd3, 1'b1, 1'b0);
    do_read(2'd3, "R6 exponent saturates");
    do_write(4, 2'd3, 1'b0, 1'b1);
    do_read(2'd3, "R6 R8 saturated held flag cleared");
    idle();

    // Read and write to the same entry in one cycle: old value returned.
    rd_en_i = 1; rd_idx_i = 2'd1;
    exp_q.push_back({m_flag[1], m_exp[1]});
    tag_q.push_back("R2 read-before-write");
    do_write(3, 2'd1, 1'b0, 1'b0);
    rd_en_i = 0;
    read_all("R9 entries after same-cycle access");

    // Start wins over a simultaneous write.
    start_i = 1;
    do_write(0, 2'd0, 1'b1, 1'b1);
    start_i = 0;
    model_clear();
    read_all("R7 start beats write R1");

    // Mixed traffic.
    for (int n = 0; n < 300; n++) begin
      if ($urandom_range(0, 9) == 0) begin
        start_i = 1; @(negedge clk); start_i = 0; model_clear();
      end else begin
        do_write(int'($urandom_range(0, 5)), IDX_W'($urandom_range(0, BMAX - 1)),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      end
      do_read(IDX_W'($urandom_range(0, BMAX - 1)), "R3 R4 R5 mixed traffic");
    end
    read_all("R9 final contents");
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all reads answered", exp_q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule